// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two ALU operands in the execute stage of a five-stage in-order integer pipeline takes its value from. It looks at the two source register numbers of the instruction now in execute. It compares them with the destination register numbers and write flags of the two older instructions that are still in flight: the one in the memory stage and the one in the write-back stage. For each operand it produces a 2-bit select that the operand multiplexer uses. The select picks the register-file read value, the result held after the execute stage, or the result held after the memory stage. This lets a dependent instruction issue directly behind its producer without waiting.

To make the bypass decision observable over time, the block holds its own copy of the three pipeline latch fields. On each advance, a decoded instruction (two sources, one destination, one write flag) enters the decode/execute latch. The older destination fields shift down to the memory and write-back latches at the same time. When the advance input is low, all three latches keep their contents. The selects are combinational functions of the latch contents. The register file is assumed to finish its write before its read in the same cycle. Because of that, a producer three or more instructions older than the consumer needs no bypass.

Top module: `fwd_unit_top`

## Requirements
- R1: While reset is applied and after it is released, before any instruction has been advanced in, both selects are 00.
- R2: Operand A's select is 10 (memory-stage result) when the memory-stage latch has its write flag set, a destination other than register 0, and a destination equal to the execute instruction's first source.
- R3: Operand B's select is 10 under the same conditions, with the test made against the execute instruction's second source.
- R4: Operand A's select is 01 (write-back-stage result) when the write-back latch has its write flag set, a destination other than register 0, and a destination equal to the first source, and R2 does not apply.
- R5: Operand B's select is 01 under the R4 conditions, with the test made against the second source, and R3 does not apply.
- R6: When both older instructions match the same operand, the select for that operand is 10: the younger producer wins.
- R7: A producer whose destination is register 0 never causes a bypass, even when its write flag is set and the source is also 0.
- R8: A producer whose write flag is clear never causes a bypass, whatever its destination.
- R9: When no producer qualifies, the select is 00. The value 11 never appears on either select.
- R10: While the advance input is low, the three latches hold their contents, the selects do not change, and the decoded-instruction inputs have no effect.
- R11: Each advance moves a destination from decode/execute to memory, and then on the next advance to write-back. A consumer one instruction behind its producer gets 10, two behind gets 01, and three behind gets 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| step_en | input | 1 | Advance: shifts a new decoded instruction into the latches |
| dec_rs | input | REG_W | First source register number of the incoming instruction |
| dec_rt | input | REG_W | Second source register number of the incoming instruction |
| dec_rd | input | REG_W | Destination register number of the incoming instruction |
| dec_wr | input | 1 | Write flag of the incoming instruction |
| sel_a | output | 2 | Operand A select: 00 register file, 10 memory-stage result, 01 write-back result |
| sel_b | output | 2 | Operand B select, same encoding |

## Verification
The selects are combinational on the latches. A result is therefore due in the first cycle after the clock edge that advanced the consumer into execute, and it stays valid until the next advance. The bench drives the inputs on the falling edge, advances on one rising edge, and reads both selects on the following falling edge. It sweeps every combination of write flags, destinations and sources over registers 0 to 2 for the two producers. It compares each result with a select worked out arithmetically from the requirements. Reset release passes through two synchroniser flops, so the bench waits several cycles after deasserting reset before the first advance.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source encoding shared by the selector and the checker.
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_WBACK = 2'b01,
    SEL_MEMST = 2'b10
  } fwd_sel_e;

  localparam int DEF_REG_W = 5;
  localparam int NUM_OPS   = 2;
endpackage

// File: rtl/fwd_stage_reg.sv
module fwd_stage_reg #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             prod_wr,
  input  logic [REG_W-1:0] prod_rd,
  output logic             hit
);
  logic rd_live;

  // register 0 is hardwired, so it never carries a forwardable value
  assign rd_live = prod_wr && (prod_rd != '0);
  assign hit     = rd_live && (prod_rd == src);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel (
  input  logic       hit_near,
  input  logic       hit_far,
  output logic [1:0] sel
);
  import fwd_pkg::*;
  fwd_sel_e pick;

  always_comb begin
    pick = SEL_RF;
    if (hit_near)     pick = SEL_MEMST;
    else if (hit_far) pick = SEL_WBACK;
  end

  assign sel = pick;
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top #(
  parameter int REG_W = fwd_pkg::DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic [REG_W-1:0] dec_rd,
  input  logic             dec_wr,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NOPS   = fwd_pkg::NUM_OPS;
  localparam int PROD_W = REG_W + 1;
  localparam int IDEX_W = 3 * REG_W + 1;

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  // decode/execute latch: sources, destination and write flag
  logic [IDEX_W-1:0] idex_q;
  fwd_stage_reg #(.WIDTH(IDEX_W)) u_idex (
    .clk(clk), .rst_n(rst_n_sync), .en(step_en),
    .d({dec_wr, dec_rd, dec_rt, dec_rs}), .q(idex_q)
  );

  logic [REG_W-1:0] id_rs_q, id_rt_q, id_rd_q;
  logic             id_wr_q;
  assign {id_wr_q, id_rd_q, id_rt_q, id_rs_q} = idex_q;

  // memory-stage latch: producer fields only
  logic [PROD_W-1:0] exmem_q;
  fwd_stage_reg #(.WIDTH(PROD_W)) u_exmem (
    .clk(clk), .rst_n(rst_n_sync), .en(step_en),
    .d({id_wr_q, id_rd_q}), .q(exmem_q)
  );

  logic [REG_W-1:0] ex_rd_q;
  logic             ex_wr_q;
  assign {ex_wr_q, ex_rd_q} = exmem_q;

  // write-back latch
  logic [PROD_W-1:0] memwb_q;
  fwd_stage_reg #(.WIDTH(PROD_W)) u_memwb (
    .clk(clk), .rst_n(rst_n_sync), .en(step_en),
    .d(exmem_q), .q(memwb_q)
  );

  logic [REG_W-1:0] wb_rd_q;
  logic             wb_wr_q;
  assign {wb_wr_q, wb_rd_q} = memwb_q;

  // per-operand comparison and priority
  logic [NOPS-1:0][REG_W-1:0] src_vec;
  logic [NOPS-1:0][1:0]       sel_vec;
  assign src_vec[0] = id_rs_q;
  assign src_vec[1] = id_rt_q;

  for (genvar op = 0; op < NOPS; op++) begin : g_op
    logic hit_near, hit_far;

    fwd_src_match #(.REG_W(REG_W)) u_near (
      .src(src_vec[op]), .prod_wr(ex_wr_q), .prod_rd(ex_rd_q), .hit(hit_near)
    );
    fwd_src_match #(.REG_W(REG_W)) u_far (
      .src(src_vec[op]), .prod_wr(wb_wr_q), .prod_rd(wb_rd_q), .hit(hit_far)
    );
    fwd_operand_sel u_sel (
      .hit_near(hit_near), .hit_far(hit_far), .sel(sel_vec[op])
    );
  end

  assign sel_a = sel_vec[0];
  assign sel_b = sel_vec[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic [REG_W-1:0] id_rs_q,
  input logic [REG_W-1:0] id_rt_q,
  input logic [REG_W-1:0] id_rd_q,
  input logic             id_wr_q,
  input logic [REG_W-1:0] ex_rd_q,
  input logic             ex_wr_q,
  input logic [REG_W-1:0] wb_rd_q,
  input logic             wb_wr_q
);
  // R9
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  // R2
  near_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10) |-> (ex_wr_q && ex_rd_q != '0 && ex_rd_q == id_rs_q));

  // R3
  near_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'b10) |-> (ex_wr_q && ex_rd_q != '0 && ex_rd_q == id_rt_q));

  // R4
  far_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b01) |-> (wb_wr_q && wb_rd_q != '0 && wb_rd_q == id_rs_q
                          && !(ex_wr_q && ex_rd_q == id_rs_q)));

  // R5
  far_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'b01) |-> (wb_wr_q && wb_rd_q != '0 && wb_rd_q == id_rt_q
                          && !(ex_wr_q && ex_rd_q == id_rt_q)));

  // R6
  near_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wr_q && ex_rd_q != '0 && ex_rd_q == id_rs_q) |-> (sel_a == 2'b10));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(sel_a) && $stable(sel_b)));

  // R11
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (ex_rd_q == $past(id_rd_q) && ex_wr_q == $past(id_wr_q)
                 && wb_rd_q == $past(ex_rd_q) && wb_wr_q == $past(ex_wr_q)));
endmodule

bind fwd_unit_top fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .step_en(step_en),
  .sel_a(sel_a), .sel_b(sel_b),
  .id_rs_q(id_rs_q), .id_rt_q(id_rt_q), .id_rd_q(id_rd_q), .id_wr_q(id_wr_q),
  .ex_rd_q(ex_rd_q), .ex_wr_q(ex_wr_q), .wb_rd_q(wb_rd_q), .wb_wr_q(wb_wr_q)
);

// File: tb/fwd_unit_top_bench.sv
`timescale 1ns/1ps
module fwd_unit_top_bench;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic [RW-1:0] dec_rs, dec_rt, dec_rd;
  logic          dec_wr;
  logic [1:0]    sel_a, sel_b;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench model of the three most recent instructions
  logic [RW-1:0] m_rs, m_rt, m_rd1, m_rd2;
  logic          m_wr1, m_wr2, m_idwr;
  logic [RW-1:0] m_idrd;

  always #2.5 clk = ~clk;

  fwd_unit_top #(.REG_W(RW)) u_fwd_unit_top (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd), .dec_wr(dec_wr),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] s);
    if (m_wr1 && m_rd1 != 0 && m_rd1 == s) return 2'b10;
    if (m_wr2 && m_rd2 != 0 && m_rd2 == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [RW-1:0] s, input bit is_b);
    bit nh, fh;
    nh = m_wr1 && m_rd1 != 0 && m_rd1 == s;
    fh = m_wr2 && m_rd2 != 0 && m_rd2 == s;
    if (nh && fh) return "R6";
    if (nh) return is_b ? "R3" : "R2";
    if (fh) return is_b ? "R5" : "R4";
    if ((m_rd1 == s && m_rd1 == 0 && m_wr1) || (m_rd2 == s && m_rd2 == 0 && m_wr2))
      return "R7";
    if (m_rd1 == s || m_rd2 == s) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive on falling edge, advance on rising edge, sample on next falling edge
  task automatic step(input logic [RW-1:0] rs, rt, rd, input logic wr);
    @(negedge clk);
    dec_rs = rs; dec_rt = rt; dec_rd = rd; dec_wr = wr; step_en = 1'b1;
    @(posedge clk);
    m_rd2 = m_rd1; m_wr2 = m_wr1;
    m_rd1 = m_idrd; m_wr1 = m_idwr;
    m_idrd = rd; m_idwr = wr; m_rs = rs; m_rt = rt;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic check_both();
    check(tag_of(m_rs, 1'b0), sel_a, exp_sel(m_rs));
    check(tag_of(m_rt, 1'b1), sel_b, exp_sel(m_rt));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; step_en = 1'b0;
    dec_rs = '0; dec_rt = '0; dec_rd = '0; dec_wr = 1'b0;
    m_rs = '0; m_rt = '0; m_rd1 = '0; m_rd2 = '0; m_idrd = '0;
    m_wr1 = 1'b0; m_wr2 = 1'b0; m_idwr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", sel_a, 2'b00);
    check("R1", sel_b, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check("R1", sel_a, 2'b00);
    check("R1", sel_b, 2'b00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin : stimulus
    logic [1:0] hold_a, hold_b;
    rst_n = 1'b0; step_en = 1'b0;
    dec_rs = '0; dec_rt = '0; dec_rd = '0; dec_wr = 1'b0;
    apply_reset();

    // exhaustive sweep: R2..R9 over registers 0..2 for both producers
    for (int fw = 0; fw < 2; fw++)
      for (int fr = 0; fr < 3; fr++)
        for (int nw = 0; nw < 2; nw++)
          for (int nr = 0; nr < 3; nr++)
            for (int rs = 0; rs < 3; rs++)
              for (int rt = 0; rt < 3; rt++) begin
                step(5'd0, 5'd0, RW'(fr), fw[0]);
                step(5'd0, 5'd0, RW'(nr), nw[0]);
                step(RW'(rs), RW'(rt), 5'd0, 1'b0);
                check_both();
              end

    // R11: distance 1, 2, 3 from a producer of register 7
    step(5'd0, 5'd0, 5'd7, 1'b1);
    step(5'd7, 5'd1, 5'd0, 1'b0);
    check("R11", sel_a, 2'b10);
    step(5'd1, 5'd7, 5'd0, 1'b0);
    check("R11", sel_b, 2'b01);
    step(5'd7, 5'd7, 5'd0, 1'b0);
    check("R11", sel_a, 2'b00);
    check("R11", sel_b, 2'b00);

    // R10: advance low, inputs changed, selects must hold
    step(5'd0, 5'd0, 5'd9, 1'b1);
    step(5'd9, 5'd4, 5'd4, 1'b1);
    hold_a = sel_a; hold_b = sel_b;
    check("R10", hold_a, 2'b10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dec_rs = RW'(k + 3); dec_rt = 5'd9; dec_rd = 5'd9; dec_wr = 1'b1;
      @(negedge clk);
      check("R10", sel_a, hold_a);
      check("R10", sel_b, hold_b);
    end
    // after the hold, the earlier producer order is unchanged
    step(5'd4, 5'd9, 5'd0, 1'b0);
    check("R10", sel_a, 2'b10);
    check("R10", sel_b, 2'b01);

    // R1 again after a mid-run reset
    apply_reset();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule